// File: doc/BRIEF.md
# Floating-Point Control Register File

This block keeps the floating-point control and status word of a processor, together with a fixed implementation/revision word. The CPU reaches these through two kinds of control access. A move-from returns a register, and a move-to writes one. Each access carries a 5-bit register index. Write data is 32 bits wide. Read data is sign-extended to the general register width.

Besides the full status word, four narrower alias views are offered:

- a packed condition-code view, which closes the hole in the condition-code bit positions;
- an exception view, which holds cause and sticky flags;
- a control view, which holds enables and rounding mode, with flush-to-zero moved down to bit 2;
- the implementation word.

Any write that can alter cause or enable bits is checked. If the result calls for a floating-point exception, a one-cycle trap request is issued. Indices that are not implemented are ignored.

Top module: `fpu_ctrl_regs`

## Requirements
- R1: After a synchronous active-low reset the status word is zero, `rd_valid` and `trap_o` are low, and a read of index 0 returns the `IMPL_ID` parameter sign-extended.
- R2: Index 31 reads and writes the full status word. Status bits 22:18 are always zero, whatever was written.
- R3: A read of index 25 returns the condition codes packed into bits 7:0, with upper bits zero. Packed bit 0 is status bit 23, and packed bits 7:1 are status bits 31:25.
- R4: A write to index 25 puts write bit 0 into status bit 23 and write bits 7:1 into status bits 31:25. Every other status bit, including flush-to-zero at bit 24, is kept. This write never raises a trap.
- R5: Index 26 reads cause (bits 17:12) and flags (bits 6:2) in place, with all other bits zero. A write to index 26 replaces only those two fields.
- R6: A read of index 28 returns enables (bits 11:7) and rounding mode (bits 1:0) in place, plus flush-to-zero (status bit 24) at bit 2. A write to index 28 works as follows:
  - it takes flush-to-zero from write bit 2;
  - it replaces enables and rounding mode;
  - it keeps condition codes, cause and flags.
- R7: After a write to index 26, 28 or 31, `trap_o` pulses if cause bit k (status bit 12+k, k in 0..4) and enable bit k (status bit 7+k) are both set in the new word.
- R8: After a write to index 26, 28 or 31, `trap_o` pulses whenever cause bit 5 (status bit 17) is set, whatever the enables hold.
- R9: A read of any index other than 0, 25, 26, 28 and 31 leaves `rd_valid` low and `rd_data` unchanged. A write to any index other than 25, 26, 28 and 31 (index 0 included) leaves the status word unchanged.
- R10: `rd_data`/`rd_valid` are registered and appear one cycle after `rd_en`. When a read and a write happen in the same cycle, the read returns the word as it was before that write. `trap_o` and `status_o` update on the same edge that takes the write, and `trap_o` lasts one cycle.
- R11: Every read value is the 32-bit view sign-extended from bit 31 to `XLEN` bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_en | input | 1 | Control read request |
| rd_idx | input | 5 | Control read register index |
| wr_en | input | 1 | Control write request |
| wr_idx | input | 5 | Control write register index |
| wr_data | input | 32 | Control write data |
| rd_data | output | XLEN (64) | Registered, sign-extended read data |
| rd_valid | output | 1 | Read hit an implemented index, one cycle after the request |
| trap_o | output | 1 | One-cycle floating-point exception request |
| status_o | output | 32 | Current full status word |

## Verification
Read results are due exactly one clock edge after `rd_en` is sampled. Trap and status results are due on the edge that samples `wr_en`. Inputs are driven on a falling edge, and each result is sampled on the next falling edge, which is the earliest point where it is stable. One extra falling edge after a trapping write confirms that `trap_o` has dropped again.

Every index is written with walking-one and dense patterns. Each write is followed by a read of that index and of all implemented views, and all results are compared with a bench model. A combined read-and-write cycle confirms the pre-write read ordering.

// File: rtl/fcr_pkg.sv
// Package: field positions, masks, register indices and the index decoder
// shared by the floating-point control register file. Assumes a 32-bit
// status word with the condition-code hole at bit 24.
package fcr_pkg;

    localparam int unsigned WORD_W    = 32;
    localparam int unsigned IDX_W     = 5;
    localparam int unsigned N_MASKED  = 5;   // cause bits gated by enables
    localparam int unsigned N_CAUSE   = 6;   // includes the unmaskable one
    localparam int unsigned N_CC      = 8;

    localparam int unsigned POS_RM    = 0;
    localparam int unsigned POS_FLAG  = 2;
    localparam int unsigned POS_EN    = 7;
    localparam int unsigned POS_CAUSE = 12;
    localparam int unsigned POS_CC0   = 23;
    localparam int unsigned POS_FTZ   = 24;
    localparam int unsigned POS_CCHI  = 25;
    localparam int unsigned POS_FTZ_ALIAS = 2;

    localparam logic [WORD_W-1:0] MASK_RSV = 32'h007C_0000;
    localparam logic [WORD_W-1:0] MASK_EXC = 32'h0003_F07C;
    localparam logic [WORD_W-1:0] MASK_CTL = 32'h0000_0F83;
    localparam logic [WORD_W-1:0] MASK_CC  = 32'hFE80_0000;

    localparam logic [IDX_W-1:0] IDX_IDENT = 5'd0;
    localparam logic [IDX_W-1:0] IDX_CCV   = 5'd25;
    localparam logic [IDX_W-1:0] IDX_EXCV  = 5'd26;
    localparam logic [IDX_W-1:0] IDX_CTLV  = 5'd28;
    localparam logic [IDX_W-1:0] IDX_FULL  = 5'd31;

    typedef enum logic [2:0] {
        VW_NONE,
        VW_IDENT,
        VW_CC,
        VW_EXC,
        VW_CTL,
        VW_FULL
    } view_e;

    // Map a register index onto the view it selects.
    function automatic view_e decode_view(input logic [IDX_W-1:0] idx);
        view_e v;
        case (idx)
            IDX_IDENT: v = VW_IDENT;
            IDX_CCV:   v = VW_CC;
            IDX_EXCV:  v = VW_EXC;
            IDX_CTLV:  v = VW_CTL;
            IDX_FULL:  v = VW_FULL;
            default:   v = VW_NONE;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/fcr_view_read.sv
// Module: fcr_view_read
// Combinational read-view formatter. Builds the 32-bit view selected by the
// index from the status word, then sign-extends it to XLEN. Assumes
// XLEN > 32 and that reserved status bits are already zero.
module fcr_view_read
    import fcr_pkg::*;
#(
    parameter logic [31:0] IMPL_ID = 32'h0000_0B27,
    parameter int unsigned XLEN    = 64
) (
    input  logic [IDX_W-1:0]  idx,
    input  logic [WORD_W-1:0] status,
    output logic              hit,
    output logic [XLEN-1:0]   data
);
    localparam int unsigned EXT_W = XLEN - WORD_W;

    logic [WORD_W-1:0] view_w;
    logic [N_CC-1:0]   packed_cc;

    // Gather the condition codes into a dense byte, closing the hole.
    always_comb begin
        packed_cc = {status[WORD_W-1:POS_CCHI], status[POS_CC0]};
    end

    // Select the view for the requested index.
    always_comb begin
        hit    = 1'b1;
        view_w = '0;
        unique case (decode_view(idx))
            VW_IDENT: view_w = IMPL_ID;
            VW_CC:    view_w = {{(WORD_W-N_CC){1'b0}}, packed_cc};
            VW_EXC:   view_w = status & MASK_EXC;
            VW_CTL: begin
                view_w = status & MASK_CTL;
                view_w[POS_FTZ_ALIAS] = status[POS_FTZ];
            end
            VW_FULL:  view_w = status;
            default:  hit = 1'b0;
        endcase
    end

    // Sign-extend to the general register width.
    always_comb begin
        data = {{EXT_W{view_w[WORD_W-1]}}, view_w};
    end

endmodule

// File: rtl/fcr_write_merge.sv
// Module: fcr_write_merge
// Combinational write merger. Computes the next status word for a write
// through any view and flags whether the exception check must follow.
// Assumes the caller gates wr_en; unimplemented indices leave the word as is.
module fcr_write_merge
    import fcr_pkg::*;
(
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WORD_W-1:0] wdata,
    input  logic [WORD_W-1:0] status,
    output logic [WORD_W-1:0] nxt_status,
    output logic              need_check
);
    // Merge the written view into the held word.
    always_comb begin
        nxt_status = status;
        need_check = 1'b0;
        if (wr_en) begin
            unique case (decode_view(idx))
                VW_CC: begin
                    nxt_status[POS_CC0]             = wdata[0];
                    nxt_status[WORD_W-1:POS_CCHI]   = wdata[N_CC-1:1];
                end
                VW_EXC: begin
                    nxt_status = (status & ~MASK_EXC) | (wdata & MASK_EXC);
                    need_check = 1'b1;
                end
                VW_CTL: begin
                    nxt_status = (status & (MASK_CC | MASK_EXC)) | (wdata & MASK_CTL);
                    nxt_status[POS_FTZ] = wdata[POS_FTZ_ALIAS];
                    need_check = 1'b1;
                end
                VW_FULL: begin
                    nxt_status = wdata & ~MASK_RSV;
                    need_check = 1'b1;
                end
                default: begin
                    nxt_status = status;
                end
            endcase
        end
    end

endmodule

// File: rtl/fcr_trap_check.sv
// Module: fcr_trap_check
// Combinational exception test on a status word. One lane per maskable
// cause bit ANDs cause with its enable; the top cause bit traps unmasked.
module fcr_trap_check
    import fcr_pkg::*;
(
    input  logic [N_CAUSE-1:0]  cause,
    input  logic [N_MASKED-1:0] enable,
    output logic                trap
);
    logic [N_MASKED-1:0] lane_hit;

    for (genvar k = 0; k < N_MASKED; k++) begin : g_lane
        // Cause k is reported only when its enable is set.
        always_comb begin
            lane_hit[k] = cause[k] & enable[k];
        end
    end

    // Any enabled cause, or the unmaskable cause, requests a trap.
    always_comb begin
        trap = (|lane_hit) | cause[N_CAUSE-1];
    end

endmodule

// File: rtl/fpu_ctrl_regs.sv
// Module: fpu_ctrl_regs (top)
// Floating-point control register file: holds the status word, serves
// indexed control reads (registered, sign-extended) and writes, and
// issues a one-cycle trap request after writes that may change cause or
// enable bits. Assumes one read and one write port, synchronous reset.
module fpu_ctrl_regs
    import fcr_pkg::*;
#(
    parameter logic [31:0] IMPL_ID = 32'h0000_0B27,
    parameter int unsigned XLEN    = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [4:0]        rd_idx,
    input  logic              wr_en,
    input  logic [4:0]        wr_idx,
    input  logic [31:0]       wr_data,
    output logic [XLEN-1:0]   rd_data,
    output logic              rd_valid,
    output logic              trap_o,
    output logic [31:0]       status_o
);
    logic [WORD_W-1:0] status_q;
    logic [WORD_W-1:0] status_d;
    logic              check_d;
    logic              trap_d;
    logic              view_hit;
    logic [XLEN-1:0]   view_data;
    logic [XLEN-1:0]   rd_data_q;
    logic              rd_valid_q;
    logic              trap_q;

    fcr_view_read #(
        .IMPL_ID (IMPL_ID),
        .XLEN    (XLEN)
    ) u_view (
        .idx    (rd_idx),
        .status (status_q),
        .hit    (view_hit),
        .data   (view_data)
    );

    fcr_write_merge u_merge (
        .wr_en      (wr_en),
        .idx        (wr_idx),
        .wdata      (wr_data),
        .status     (status_q),
        .nxt_status (status_d),
        .need_check (check_d)
    );

    fcr_trap_check u_trap (
        .cause  (status_d[POS_CAUSE +: N_CAUSE]),
        .enable (status_d[POS_EN +: N_MASKED]),
        .trap   (trap_d)
    );

    // Status word register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= status_d;
    end

    // Trap pulse: set only on a checked write whose result traps.
    always_ff @(posedge clk) begin
        if (!rst_n) trap_q <= 1'b0;
        else        trap_q <= check_d & trap_d;
    end

    // Read port: capture on hit, hold data otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data_q  <= '0;
            rd_valid_q <= 1'b0;
        end else begin
            rd_valid_q <= rd_en & view_hit;
            if (rd_en && view_hit) rd_data_q <= view_data;
        end
    end

    assign rd_data  = rd_data_q;
    assign rd_valid = rd_valid_q;
    assign trap_o   = trap_q;
    assign status_o = status_q;

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q & MASK_RSV) == '0);                                                   // R2
    AST_CC_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == IDX_CCV) |=> (status_q[POS_FTZ:0] & ~32'h0080_0000) == ($past(status_q[POS_FTZ:0]) & ~32'h0080_0000) && !trap_o); // R4
    AST_UNMASKED_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == IDX_FULL && wr_data[POS_CAUSE+N_CAUSE-1]) |=> trap_o);      // R8
    AST_TRAP_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> $past(wr_en));                                                       // R7
    AST_RDV_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_en));                                                     // R10
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(status_q));                                                  // R9
    AST_NOREAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data) && !rd_valid);                                      // R9

endmodule

// File: tb/fpu_ctrl_regs_tb_top.sv
// Bench: sweeps every index with walking-one and dense patterns, checking
// status, trap and all read views against an arithmetic model.
module fpu_ctrl_regs_tb_top;
    localparam logic [31:0] ID_VAL = 32'h0000_0B27;
    localparam int unsigned XW     = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd_en = 1'b0;
    logic [4:0]    rd_idx = '0;
    logic          wr_en = 1'b0;
    logic [4:0]    wr_idx = '0;
    logic [31:0]   wr_data = '0;
    logic [XW-1:0] rd_data;
    logic          rd_valid;
    logic          trap_o;
    logic [31:0]   status_o;

    int checks = 0;
    int errors = 0;
    logic [31:0]   model = '0;
    logic [XW-1:0] last_rd = '0;

    always #10 clk = ~clk;   // 50 MHz

    fpu_ctrl_regs #(.IMPL_ID(ID_VAL), .XLEN(XW)) dut_i (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_idx(rd_idx),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_data(rd_data), .rd_valid(rd_valid), .trap_o(trap_o),
        .status_o(status_o));

    task automatic check(input bit ok, input string req, input logic [XW-1:0] act, input logic [XW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [XW-1:0] sext(input logic [31:0] v);
        return {{(XW-32){v[31]}}, v};
    endfunction

    // Expected view for a read; valid flag returned through ok.
    function automatic logic [31:0] m_read(input int idx, input logic [31:0] s, output bit ok);
        logic [31:0] v;
        ok = 1; v = 0;
        case (idx)
            0:  v = ID_VAL;
            25: begin v[0] = s[23]; for (int j = 1; j < 8; j++) v[j] = s[24+j]; end
            26: begin for (int j = 2; j <= 6; j++) v[j] = s[j]; for (int j = 12; j <= 17; j++) v[j] = s[j]; end
            28: begin v[1:0] = s[1:0]; for (int j = 7; j <= 11; j++) v[j] = s[j]; v[2] = s[24]; end
            31: v = s;
            default: ok = 0;
        endcase
        return v;
    endfunction

    // Next model word for a write; chk says whether the trap test follows.
    function automatic logic [31:0] m_write(input int idx, input logic [31:0] s, input logic [31:0] w, output bit chk);
        logic [31:0] n;
        n = s; chk = 0;
        case (idx)
            25: begin n[23] = w[0]; for (int j = 1; j < 8; j++) n[24+j] = w[j]; end
            26: begin for (int j = 2; j <= 6; j++) n[j] = w[j]; for (int j = 12; j <= 17; j++) n[j] = w[j]; chk = 1; end
            28: begin n[1:0] = w[1:0]; for (int j = 7; j <= 11; j++) n[j] = w[j]; n[24] = w[2]; chk = 1; end
            31: begin n = w; for (int j = 18; j <= 22; j++) n[j] = 1'b0; chk = 1; end
            default: ;
        endcase
        return n;
    endfunction

    function automatic bit m_trap(input logic [31:0] s);
        bit t;
        t = s[17];
        for (int k = 0; k < 5; k++) t = t | (s[12+k] & s[7+k]);
        return t;
    endfunction

    task automatic do_write(input int idx, input logic [31:0] v);
        bit chk, expt;
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx[4:0]; wr_data = v;
        model = m_write(idx, model, v, chk);
        expt = chk && m_trap(model);
        @(negedge clk);
        wr_en = 1'b0;
        check(status_o == model, (idx == 25) ? "R4 cc write" : (idx == 26) ? "R5 exc write" :
              (idx == 28) ? "R6 ctl write" : (idx == 31) ? "R2 full write" : "R9 ignored write",
              {32'h0, status_o}, {32'h0, model});
        check(trap_o == expt, model[17] ? "R8 unmaskable trap" : "R7 enabled trap",
              {63'h0, trap_o}, {63'h0, expt});
        if (expt) begin
            @(negedge clk);
            check(trap_o == 1'b0, "R10 trap one cycle", {63'h0, trap_o}, 64'h0);
        end
    endtask

    task automatic do_read(input int idx);
        bit ok;
        logic [31:0] v;
        logic [XW-1:0] e;
        v = m_read(idx, model, ok);
        @(negedge clk);
        rd_en = 1'b1; rd_idx = idx[4:0];
        @(negedge clk);
        rd_en = 1'b0;
        e = ok ? sext(v) : last_rd;
        check(rd_valid == ok, ok ? "R10 read valid" : "R9 unimpl read valid",
              {63'h0, rd_valid}, {63'h0, ok});
        check(rd_data == e, (idx == 0) ? "R1 ident read" : (idx == 25) ? "R3 cc read" :
              (idx == 26) ? "R5 exc read" : (idx == 28) ? "R6 ctl read" :
              (idx == 31) ? "R11 full read sext" : "R9 unimpl read hold", rd_data, e);
        last_rd = e;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int impl[5];
        impl = '{0, 25, 26, 28, 31};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(status_o == 32'h0, "R1 reset status", {32'h0, status_o}, 64'h0);
        check(rd_valid == 1'b0, "R1 reset rd_valid", {63'h0, rd_valid}, 64'h0);
        check(trap_o == 1'b0, "R1 reset trap", {63'h0, trap_o}, 64'h0);
        do_read(0);

        for (int i = 0; i < 32; i++) begin
            for (int p = 0; p < 36; p++) begin
                logic [31:0] v;
                if (p < 32) v = 32'h1 << p;
                else if (p == 32) v = 32'hFFFF_FFFF;
                else if (p == 33) v = 32'h0;
                else if (p == 34) v = 32'hA5A5_A5A5;
                else v = 32'h5A5A_5A5A;
                do_write(i, v);
                do_read(i);
                for (int r = 0; r < 5; r++) do_read(impl[r]);
            end
        end

        // R10: read and write in the same cycle returns the old word.
        do_write(31, 32'h1234_0000);
        @(negedge clk);
        rd_en = 1'b1; rd_idx = 5'd31; wr_en = 1'b1; wr_idx = 5'd31; wr_data = 32'h8000_0003;
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
        check(rd_data == sext(32'h1200_0000 | 32'h0034_0000 & 32'hFF83_FFFF),
              "R10 read before write", rd_data, sext(32'h1200_0000 | 32'h0034_0000 & 32'hFF83_FFFF));
        model = 32'h8000_0003;
        last_rd = rd_data;
        do_read(31);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule